// File: doc/BRIEF.md
# Indexed Store Sequencer with Bus-Conflict Corruption

This block runs the bus cycles of a byte-wide processor's absolute-indexed store once the opcode has been fetched. It covers plain stores of the accumulator indexed by X or Y, and three undocumented stores. In those three, an internal bus conflict ANDs the stored register with the incremented base high byte. The caller pulses `start` with the opcode, the address of the first operand byte and the three register values. The sequencer then reads the low and high operand bytes, performs a dummy read and finally writes one byte.

For the undocumented stores, the data that lands in memory is the source register ANDed with (base high byte + 1). When adding the index to the low byte carries out of the page, the high byte of the write address is replaced by that same corrupted value. The low byte stays the wrapped sum. Without a carry, the write address is the normal sum. Plain stores always write A to the fully carried address.

Top module: `ixs_store_seq`

## Requirements
- R1: After reset, `rd_en`, `wr_en` and `done` are 0 and `addr` is 0.
- R2: An accepted `start` is followed by exactly four bus cycles, one per clock: read at `oper_pc`, read at `oper_pc+1` (16-bit wrap), a dummy read, and a write. `done` is 1 for exactly the one cycle after the write.
- R3: The dummy read address is {operand high byte, low 8 bits of (operand low byte + index)}, with no carry correction.
- R4: Opcode 0x9D (index X) and opcode 0x99 (index Y) write A to the 16-bit operand plus the index, with a 16-bit wrap.
- R5: Opcode 0x9C uses X as the index and writes Y AND (operand high + 1, 8-bit wrap).
- R6: Opcode 0x9E uses Y as the index and writes X AND (operand high + 1).
- R7: Opcode 0x9F uses Y as the index and writes A AND X AND (operand high + 1).
- R8: For 0x9C/0x9E/0x9F, when operand low + index exceeds 0xFF, the write address is {written data, wrapped low sum}. Otherwise it is the normal 16-bit sum.
- R9: A `start` with any opcode other than the five listed causes no strobe and no `done`.
- R10: A `start` that arrives while a sequence is in progress is ignored and leaves that sequence unchanged.
- R11: `wr_en` is 1 only in the write cycle. `rd_en` and `wr_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a store; sampled only when idle |
| opcode | input | 8 | Store opcode |
| oper_pc | input | 16 | Address of the first operand byte |
| reg_a | input | 8 | Accumulator value |
| reg_x | input | 8 | X register value |
| reg_y | input | 8 | Y register value |
| rd_data | input | 8 | Memory read data, valid in the read cycle |
| addr | output | 16 | Bus address |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| wr_data | output | 8 | Write data |
| done | output | 1 | One-cycle pulse after the write |

## Verification
The bench targets page crossings on the undocumented stores. A design that carried normally there would write to the wrong page, and one that corrupted the address without a crossing would hit the wrong page on ordinary stores. It also covers an operand high byte of 0xFF, where the increment wraps to zero and every corrupted store must write 0. A wrong bit width there would leak a set bit. Further cases cover a dummy read that carries by mistake (its address comes out one page high), unknown opcodes that must leave the bus idle, and a `start` received mid-sequence that a careless design would restart on.

// File: rtl/ixs_pkg.sv
package ixs_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {ST_IDLE, ST_OPLO, ST_OPHI, ST_DUMMY, ST_WRITE} seq_state_t;
  typedef enum logic [1:0] {SRC_A, SRC_X, SRC_Y, SRC_AX} src_t;

  typedef struct packed {
    logic valid;
    logic idx_is_x;
    logic corrupt;
    src_t src;
  } op_ctl_t;

  // incremented base high byte, 8-bit wrap
  function automatic logic [DW-1:0] bumped_hi(input logic [DW-1:0] hi);
    return hi + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  // value left on the conflicting internal bus
  function automatic logic [DW-1:0] conflict_val(input logic [DW-1:0] r,
                                                 input logic [DW-1:0] hi);
    return r & bumped_hi(hi);
  endfunction
endpackage

// File: rtl/ixs_decode.sv
module ixs_decode
  import ixs_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output op_ctl_t       ctl
);
  always_comb begin
    ctl = '{valid: 1'b0, idx_is_x: 1'b0, corrupt: 1'b0, src: SRC_A};
    unique case (opcode)
      8'h9D: ctl = '{valid: 1'b1, idx_is_x: 1'b1, corrupt: 1'b0, src: SRC_A};
      8'h99: ctl = '{valid: 1'b1, idx_is_x: 1'b0, corrupt: 1'b0, src: SRC_A};
      8'h9C: ctl = '{valid: 1'b1, idx_is_x: 1'b1, corrupt: 1'b1, src: SRC_Y};
      8'h9E: ctl = '{valid: 1'b1, idx_is_x: 1'b0, corrupt: 1'b1, src: SRC_X};
      8'h9F: ctl = '{valid: 1'b1, idx_is_x: 1'b0, corrupt: 1'b1, src: SRC_AX};
      default: ;
    endcase
  end
endmodule

// File: rtl/ixs_addr_unit.sv
module ixs_addr_unit
  import ixs_pkg::*;
(
  input  logic [DW-1:0] base_lo,
  input  logic [DW-1:0] base_hi,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] src_val,
  input  logic          corrupt,
  output logic [AW-1:0] dummy_addr,
  output logic [AW-1:0] write_addr,
  output logic [DW-1:0] write_data,
  output logic          page_cross
);
  logic [DW:0]   lo_sum;
  logic [DW-1:0] hi_fixed;
  logic [DW-1:0] bus_val;

  always_comb begin
    lo_sum     = {1'b0, base_lo} + {1'b0, idx};
    page_cross = lo_sum[DW];
    bus_val    = conflict_val(src_val, base_hi);
    hi_fixed   = page_cross ? bumped_hi(base_hi) : base_hi;
    dummy_addr = {base_hi, lo_sum[DW-1:0]};
    write_data = corrupt ? bus_val : src_val;
    if (corrupt && page_cross) write_addr = {bus_val, lo_sum[DW-1:0]};
    else                       write_addr = {hi_fixed, lo_sum[DW-1:0]};
  end

  always_comb begin
    // R8
    low_wrap_chk: assert (write_addr[DW-1:0] == dummy_addr[DW-1:0]);
    // R4
    if (!corrupt || !page_cross)
      plain_sum_chk: assert (write_addr == ({base_hi, base_lo} + {{DW{1'b0}}, idx}));
  end
endmodule

// File: rtl/ixs_store_seq.sv
module ixs_store_seq
  import ixs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [15:0]   oper_pc,
  input  logic [7:0]    reg_a,
  input  logic [7:0]    reg_x,
  input  logic [7:0]    reg_y,
  input  logic [7:0]    rd_data,
  output logic [15:0]   addr,
  output logic          rd_en,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          done
);
  seq_state_t    state_q;
  op_ctl_t       ctl_q, dec_ctl;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] a_q, x_q, y_q, lo_q, hi_q;
  logic          done_q;

  logic          accept;
  logic [DW-1:0] idx, src_val, w_data;
  logic [AW-1:0] dummy_addr, w_addr;
  logic          page_cross;

  ixs_decode u_dec (.opcode(opcode), .ctl(dec_ctl));

  assign accept = start && (state_q == ST_IDLE) && dec_ctl.valid;
  assign idx    = ctl_q.idx_is_x ? x_q : y_q;

  always_comb begin
    unique case (ctl_q.src)
      SRC_A:   src_val = a_q;
      SRC_X:   src_val = x_q;
      SRC_Y:   src_val = y_q;
      default: src_val = a_q & x_q;
    endcase
  end

  ixs_addr_unit u_au (
    .base_lo(lo_q), .base_hi(hi_q), .idx(idx), .src_val(src_val),
    .corrupt(ctl_q.corrupt), .dummy_addr(dummy_addr), .write_addr(w_addr),
    .write_data(w_data), .page_cross(page_cross)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      pc_q    <= '0;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_OPLO;
          ctl_q   <= dec_ctl;
          pc_q    <= oper_pc;
          a_q     <= reg_a;
          x_q     <= reg_x;
          y_q     <= reg_y;
        end
        ST_OPLO: begin lo_q <= rd_data; state_q <= ST_OPHI; end
        ST_OPHI: begin hi_q <= rd_data; state_q <= ST_DUMMY; end
        ST_DUMMY: state_q <= ST_WRITE;
        default: begin state_q <= ST_IDLE; done_q <= 1'b1; end
      endcase
    end
  end

  always_comb begin
    addr    = '0;
    rd_en   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    unique case (state_q)
      ST_OPLO:  begin addr = pc_q; rd_en = 1'b1; end
      ST_OPHI:  begin addr = pc_q + 16'd1; rd_en = 1'b1; end
      ST_DUMMY: begin addr = dummy_addr; rd_en = 1'b1; end
      ST_WRITE: begin addr = w_addr; wr_en = 1'b1; wr_data = w_data; end
      default: ;
    endcase
  end
  assign done = done_q;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  // R2
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en));
  // R2
  write_after_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));
  // R3
  dummy_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DUMMY) |-> (addr[15:8] == $past(rd_data)));
  // R8
  cross_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctl_q.corrupt && page_cross) |-> (addr[15:8] == wr_data));
endmodule

// File: tb/tb_ixs_store_seq.sv
module tb_ixs_store_seq;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] opcode = '0, reg_a = '0, reg_x = '0, reg_y = '0, rd_data;
  logic [15:0] oper_pc = '0, addr;
  logic rd_en, wr_en, done;
  logic [7:0] wr_data;
  logic [15:0] m_pc = '0;
  logic [7:0] m_lo = '0, m_hi = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ixs_store_seq dut (.*);

  always_comb begin
    if (addr == m_pc)              rd_data = m_lo;
    else if (addr == m_pc + 16'd1) rd_data = m_hi;
    else                           rd_data = 8'hA5;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(logic [7:0] op, logic [7:0] lo, logic [7:0] hi,
                                        logic [7:0] a, logic [7:0] x, logic [7:0] y);
    logic [7:0] ix, v, d;
    logic [8:0] s;
    logic [15:0] ad;
    ix = (op == 8'h9C || op == 8'h9D) ? x : y;
    s = lo + ix;
    v = (op == 8'h9C) ? y : (op == 8'h9E) ? x : (op == 8'h9F) ? (a & x) : a;
    if (op == 8'h99 || op == 8'h9D) begin
      d = a; ad = {hi, lo} + ix;
    end else begin
      d = v & (hi + 8'd1);
      ad = s[8] ? {d, s[7:0]} : {hi, lo} + ix;
    end
    return {ad, d};
  endfunction

  task automatic run_op(logic [7:0] op, logic [15:0] pc, logic [7:0] lo, logic [7:0] hi,
                        logic [7:0] a, logic [7:0] x, logic [7:0] y, bit poke);
    logic [23:0] e;
    logic [7:0] ix;
    string rq;
    e = model(op, lo, hi, a, x, y);
    ix = (op == 8'h9C || op == 8'h9D) ? x : y;
    rq = (op == 8'h9C) ? "R5" : (op == 8'h9E) ? "R6" : (op == 8'h9F) ? "R7" : "R4";
    m_pc = pc; m_lo = lo; m_hi = hi;
    start = 1; opcode = op; oper_pc = pc; reg_a = a; reg_x = x; reg_y = y;
    @(posedge clk); @(negedge clk);
    start = 0;
    chk("R2 lo read", {rd_en, wr_en, addr}, {2'b10, pc});
    if (poke) begin start = 1; opcode = 8'h9D; oper_pc = pc ^ 16'h5555; reg_a = ~a; reg_x = ~x; end
    @(posedge clk); @(negedge clk);
    start = 0;
    chk(poke ? "R10 hi read" : "R2 hi read", {rd_en, wr_en, addr}, {2'b10, pc + 16'd1});
    @(posedge clk); @(negedge clk);
    chk("R3 dummy", {rd_en, wr_en, addr}, {2'b10, hi, 8'(lo + ix)});
    @(posedge clk); @(negedge clk);
    chk({rq, " data"}, {rd_en, wr_en, wr_data}, {2'b01, e[7:0]});
    chk("R8 write addr", addr, e[23:8]);
    @(posedge clk); @(negedge clk);
    chk("R2 done", {done, rd_en, wr_en}, 3'b100);
  endtask

  initial begin
    logic [7:0] ops [5];
    void'($urandom(32'd1234));
    ops = '{8'h9C, 8'h9E, 8'h9F, 8'h9D, 8'h99};
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset", {rd_en, wr_en, done, addr}, 19'd0);
    rst_n = 1;
    @(negedge clk);
    // directed examples, R6 R8
    run_op(8'h9E, 16'h1000, 8'hF0, 8'h02, 8'h00, 8'hFD, 8'hF0, 0);
    run_op(8'h9E, 16'h1000, 8'hF0, 8'h02, 8'h00, 8'hFD, 8'h00, 0);
    // high byte FF wraps, R5 R7
    run_op(8'h9C, 16'hFFFF, 8'h80, 8'hFF, 8'hFF, 8'h90, 8'hFF, 0);
    run_op(8'h9F, 16'h2000, 8'h10, 8'hFF, 8'hFF, 8'hFF, 8'h20, 0);
    // STA crossing, R4
    run_op(8'h9D, 16'h3000, 8'hFF, 8'hFF, 8'h3C, 8'h01, 8'h00, 0);
    // busy start ignored, R10
    run_op(8'h9C, 16'h4000, 8'hC0, 8'h12, 8'h77, 8'h80, 8'hF3, 1);
    // unsupported opcode, R9
    start = 1; opcode = 8'h8D;
    @(posedge clk); @(negedge clk);
    start = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R9 ignored", {rd_en, wr_en, done}, 3'b000);
      @(posedge clk); @(negedge clk);
    end
    for (int i = 0; i < 150; i++)
      run_op(ops[$urandom_range(4, 0)], 16'($urandom), 8'($urandom), 8'($urandom),
             8'($urandom), 8'($urandom), 8'($urandom), ($urandom_range(7, 0) == 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule